// File: doc/BRIEF.md
# ADC Channel Sequence Scheduler

This block chooses the analog channel that one measurement unit converts next. Software fills a 12-by-12 bitmap. Each of the twelve sequence words holds one bit per channel. The scheduler walks this bitmap repeatedly. For every set bit it issues one conversion request that carries the channel number of that bit. Cleared bits cost no conversion. A channel's sampling rate therefore follows how often it appears in the bitmap, not a round-robin turn.

The converter side uses a request/busy/done handshake. A request is held until the converter accepts it. The scheduler then waits for a done pulse before it looks for the next set bit. Software reaches the words through a small register port that packs two words into each 32-bit location.

Alongside each request the block reports:
- the current word and bit position;
- a one-cycle end-of-round pulse;
- the number of conversions in one full round, taken from the stored bitmap.

Top module: `adc_seq_sched`

## Requirements
- R1: Scanning runs from word 0 to word 11. Within a word it runs from bit 11 down to bit 0. Each request drives `ch_o` with the bit position k, meaning channel k, and drives `word_idx_o` with the word index.
- R2: A cleared bit produces no request. The next request belongs to the next set bit in scan order.
- R3: After the last set bit of a pass, the scan wraps to word 0, bit 11. `round_end_o` is high for exactly the one cycle that follows the done pulse of that last conversion.
- R4: `period_o` equals the total number of set bits over all twelve stored words, in the range 0 to 144. It follows a register write in the next cycle.
- R5: `req_o` and `ch_o` stay steady while `busy_i` is high. The request is accepted on a clock edge where `req_o` is high and `busy_i` is low. After acceptance `req_o` is low until `done_i` has been seen, and only then can the next request start.
- R6: Register address a (0 to 5) holds word 2a in bits [11:0] and word 2a+1 in bits [27:16]. All other bits read zero and ignore writes. Addresses 6 and 7 read zero, and writes to them change nothing.
- R7: After reset:
  - words 0, 3, 6 and 9 are 0xFFF, word 1 is 0x03C, word 2 is 0x800, and all other words are zero;
  - the position is word 0, bit 11;
  - `req_o` and `round_end_o` are low.
- R8: When every bit is cleared, no request is issued while `en_i` is high.
- R9: With `en_i` low, no new request starts. A conversion already underway completes. The next enable starts the scan again from word 0, bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Scheduler run enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| req_o | output | 1 | Conversion request |
| ch_o | output | 4 | Channel number of the request |
| busy_i | input | 1 | Converter cannot accept a request |
| done_i | input | 1 | Conversion finished (one-cycle pulse) |
| word_idx_o | output | 4 | Current sequence word index |
| bit_idx_o | output | 4 | Current bit index inside the word |
| round_end_o | output | 1 | One-cycle pulse after the final conversion of a pass |
| period_o | output | 8 | Conversions per full round |

## Verification
The assertions rely on the converter following the handshake:
- it raises `done_i` only once for each accepted request;
- it raises `done_i` only after the acceptance edge.

The bench's converter model keeps this order, and it varies the busy hold time and the conversion latency between requests. The assertions also expect software to write the bitmap only while the scheduler is idle, so that a clear cannot land on a request that has already been chosen. All bitmap changes in the stimulus are made with `en_i` low and the scheduler drained.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned NUM_WORDS = 12;
  localparam int unsigned NUM_CH    = 12;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEEK,
    ST_REQ,
    ST_WAIT
  } scan_st_e;

  function automatic logic [NUM_CH-1:0] reset_word(input int unsigned idx);
    case (idx)
      0, 3, 6, 9: return 12'hFFF;
      1:          return 12'h03C;
      2:          return 12'h800;
      default:    return '0;
    endcase
  endfunction
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int unsigned N_WORDS = NUM_WORDS,
  parameter int unsigned N_CH    = NUM_CH,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PER_W   = $clog2(N_WORDS*N_CH+1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [N_WORDS-1:0][N_CH-1:0]   seq_o,
  output logic [PER_W-1:0]               period_o
);
  localparam int unsigned N_REGS = N_WORDS / 2;
  localparam int unsigned HI_LSB = DATA_W / 2;

  logic [N_WORDS-1:0][N_CH-1:0] seq_q;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        seq_q[g] <= reset_word(g);
      end else if (we_i && (int'(addr_i) == g / 2)) begin
        seq_q[g] <= (g % 2 == 0) ? wdata_i[N_CH-1:0] : wdata_i[HI_LSB +: N_CH];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < N_REGS; r++) begin
      if (int'(addr_i) == r) begin
        rdata_o[N_CH-1:0]        = seq_q[2*r];
        rdata_o[HI_LSB +: N_CH]  = seq_q[2*r+1];
      end
    end
  end

  always_comb begin
    period_o = '0;
    for (int w = 0; w < N_WORDS; w++) begin
      period_o = period_o + PER_W'($countones(seq_q[w]));
    end
  end

  assign seq_o = seq_q;

  assert_period_max_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(period_o) <= N_WORDS * N_CH);

  assert_rsvd_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(addr_i) >= N_REGS) |=> $stable(period_o));
endmodule

// File: rtl/adc_seq_scan.sv
module adc_seq_scan
  import adc_seq_pkg::*;
#(
  parameter int unsigned N_WORDS = NUM_WORDS,
  parameter int unsigned N_CH    = NUM_CH,
  parameter int unsigned WI_W    = $clog2(N_WORDS),
  parameter int unsigned BI_W    = $clog2(N_CH),
  parameter int unsigned PER_W   = $clog2(N_WORDS*N_CH+1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic [N_WORDS-1:0][N_CH-1:0] seq_i,
  input  logic [PER_W-1:0]             period_i,
  input  logic                         busy_i,
  input  logic                         done_i,
  output logic                         req_o,
  output logic [BI_W-1:0]              ch_o,
  output logic [WI_W-1:0]              word_idx_o,
  output logic [BI_W-1:0]              bit_idx_o,
  output logic                         round_end_o
);
  localparam logic [WI_W-1:0] LAST_WORD = WI_W'(N_WORDS - 1);
  localparam logic [BI_W-1:0] TOP_BIT   = BI_W'(N_CH - 1);

  scan_st_e          st_q;
  logic [WI_W-1:0]   word_q, nxt_word;
  logic [BI_W-1:0]   bit_q, hit_idx;
  logic [N_CH-1:0]   cur_w, seek_v, below_v;
  logic              hit, later_nz, last_bit, round_q;

  always_comb begin
    cur_w    = seq_i[word_q];
    seek_v   = cur_w & ({N_CH{1'b1}} >> (TOP_BIT - bit_q));
    below_v  = (bit_q == '0) ? '0 : (cur_w & ({N_CH{1'b1}} >> (N_CH - int'(bit_q))));
    nxt_word = (word_q == LAST_WORD) ? '0 : word_q + 1'b1;
  end

  // highest set bit at or below the current position
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int k = 0; k < N_CH; k++) begin
      if (seek_v[k]) begin
        hit     = 1'b1;
        hit_idx = BI_W'(k);
      end
    end
  end

  always_comb begin
    later_nz = 1'b0;
    for (int j = 0; j < N_WORDS; j++) begin
      if (j > int'(word_q) && |seq_i[j]) later_nz = 1'b1;
    end
    last_bit = ~|below_v & ~later_nz;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      word_q  <= '0;
      bit_q   <= TOP_BIT;
      round_q <= 1'b0;
    end else begin
      round_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (en_i && period_i != '0) st_q <= ST_SEEK;
        end
        ST_SEEK: begin
          if (!en_i || period_i == '0) begin
            st_q   <= ST_IDLE;
            word_q <= '0;
            bit_q  <= TOP_BIT;
          end else if (hit) begin
            bit_q <= hit_idx;
            st_q  <= ST_REQ;
          end else begin
            word_q <= nxt_word;
            bit_q  <= TOP_BIT;
          end
        end
        ST_REQ: begin
          if (!busy_i) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (done_i) begin
            round_q <= last_bit;
            if (!en_i) begin
              st_q   <= ST_IDLE;
              word_q <= '0;
              bit_q  <= TOP_BIT;
            end else begin
              st_q <= ST_SEEK;
              if (bit_q == '0) begin
                word_q <= nxt_word;
                bit_q  <= TOP_BIT;
              end else begin
                bit_q <= bit_q - 1'b1;
              end
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o       = (st_q == ST_REQ);
  assign ch_o        = bit_q;
  assign word_idx_o  = word_q;
  assign bit_idx_o   = bit_q;
  assign round_end_o = round_q;

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && busy_i) |=> (req_o && $stable(ch_o) && $stable(word_idx_o)));

  assert_accept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !busy_i) |=> !req_o);

  assert_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (int'(word_idx_o) < N_WORDS && int'(bit_idx_o) < N_CH));

  assert_round_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    round_end_o |=> !round_end_o);

  assert_no_req_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0 && !req_o) |=> !req_o);

  assert_no_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !$rose(req_o));
endmodule

// File: rtl/adc_seq_sched.sv
module adc_seq_sched
  import adc_seq_pkg::*;
#(
  parameter int unsigned N_WORDS = NUM_WORDS,
  parameter int unsigned N_CH    = NUM_CH,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned WI_W    = $clog2(N_WORDS),
  parameter int unsigned BI_W    = $clog2(N_CH),
  parameter int unsigned PER_W   = $clog2(N_WORDS*N_CH+1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              req_o,
  output logic [BI_W-1:0]   ch_o,
  input  logic              busy_i,
  input  logic              done_i,
  output logic [WI_W-1:0]   word_idx_o,
  output logic [BI_W-1:0]   bit_idx_o,
  output logic              round_end_o,
  output logic [PER_W-1:0]  period_o
);
  logic [N_WORDS-1:0][N_CH-1:0] seq;

  adc_seq_regs #(
    .N_WORDS(N_WORDS), .N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PER_W(PER_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .seq_o    (seq),
    .period_o (period_o)
  );

  adc_seq_scan #(
    .N_WORDS(N_WORDS), .N_CH(N_CH), .WI_W(WI_W), .BI_W(BI_W), .PER_W(PER_W)
  ) u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .seq_i       (seq),
    .period_i    (period_o),
    .busy_i      (busy_i),
    .done_i      (done_i),
    .req_o       (req_o),
    .ch_o        (ch_o),
    .word_idx_o  (word_idx_o),
    .bit_idx_o   (bit_idx_o),
    .round_end_o (round_end_o)
  );
endmodule

// File: tb/adc_seq_sched_tb_top.sv
module adc_seq_sched_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        req_o;
  logic [3:0]  ch_o;
  logic        busy_i = 1'b0;
  logic        done_i = 1'b0;
  logic [3:0]  word_idx_o;
  logic [3:0]  bit_idx_o;
  logic        round_end_o;
  logic [7:0]  period_o;

  always #2 clk_i = ~clk_i;

  adc_seq_sched dut_i (.*);

  typedef struct { int w; int b; bit last; } exp_t;
  exp_t exp_q[$];

  int n_vec = 0;
  int n_bad = 0;
  int n_unexp = 0;
  int n_acc = 0;
  logic [11:0] mw [12];
  int mpos_w = 0;
  int mpos_b = 11;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit any_after(input int w, input int b);
    for (int i = w; i < 12; i++)
      for (int k = 11; k >= 0; k--)
        if ((i > w || k < b) && mw[i][k]) return 1'b1;
    return 1'b0;
  endfunction

  // driver: walks the model bitmap and queues expected conversions
  task automatic push_items(input int n);
    for (int i = 0; i < n; i++) begin
      while (!mw[mpos_w][mpos_b]) begin
        if (mpos_b == 0) begin mpos_b = 11; mpos_w = (mpos_w + 1) % 12; end
        else mpos_b--;
      end
      exp_q.push_back('{w: mpos_w, b: mpos_b, last: !any_after(mpos_w, mpos_b)});
      if (mpos_b == 0) begin mpos_b = 11; mpos_w = (mpos_w + 1) % 12; end
      else mpos_b--;
    end
  endtask

  task automatic reg_wr(input int a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 3'(a); reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    if (a < 6) begin
      mw[2*a]   = d[11:0];
      mw[2*a+1] = d[27:16];
    end
  endtask

  task automatic reg_rd(input int a, input logic [31:0] e, input string req);
    @(negedge clk_i);
    reg_addr_i = 3'(a);
    #1;
    chk(reg_rdata_o == e, req, int'(reg_rdata_o), int'(e));
  endtask

  task automatic run(input int n);
    mpos_w = 0; mpos_b = 11;
    push_items(n);
    @(negedge clk_i);
    en_i = 1'b1;
    for (int t = 0; t < 20000 && (exp_q.size() != 0 || en_i); t++) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
  endtask

  // monitor / converter model
  initial begin
    forever begin
      @(negedge clk_i);
      if (req_o) begin
        exp_t e;
        int hold, lat, ch0;
        hold = n_acc % 3;
        lat  = (n_acc % 2) + 1;
        ch0  = int'(ch_o);
        busy_i = (hold != 0);
        for (int h = 0; h < hold; h++) begin
          @(negedge clk_i);
          chk(req_o && int'(ch_o) == ch0, "R5 hold", int'(ch_o), ch0);
          if (h == hold - 1) busy_i = 1'b0;
        end
        n_acc++;
        if (exp_q.size() == 0) begin
          n_unexp++;
          chk(1'b0, "R2/R8 unexpected request", int'(ch_o), -1);
          e = '{w: 0, b: 0, last: 1'b0};
        end else begin
          e = exp_q.pop_front();
          chk(int'(ch_o) == e.b, "R1/R2 channel", int'(ch_o), e.b);
          chk(int'(word_idx_o) == e.w, "R1 word", int'(word_idx_o), e.w);
        end
        if (exp_q.size() == 0) en_i = 1'b0;
        @(negedge clk_i);
        chk(!req_o, "R5 drop after accept", int'(req_o), 0);
        repeat (lat) @(negedge clk_i);
        chk(!req_o, "R5 no req before done", int'(req_o), 0);
        done_i = 1'b1;
        @(negedge clk_i);
        done_i = 1'b0;
        chk(round_end_o == e.last, "R3 round end", int'(round_end_o), int'(e.last));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 12; i++) mw[i] = adc_seq_pkg::reset_word(i);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R7 reset state
    chk(!req_o, "R7 req", int'(req_o), 0);
    chk(word_idx_o == 4'd0, "R7 word", int'(word_idx_o), 0);
    chk(bit_idx_o == 4'd11, "R7 bit", int'(bit_idx_o), 11);
    chk(!round_end_o, "R7 round", int'(round_end_o), 0);
    chk(period_o == 8'd53, "R4 default period", int'(period_o), 53);
    reg_rd(0, 32'h003C_0FFF, "R7/R6 addr0");
    reg_rd(1, 32'h0FFF_0800, "R7/R6 addr1");
    reg_rd(2, 32'h0000_0000, "R7/R6 addr2");
    reg_rd(3, 32'h0000_0FFF, "R7/R6 addr3");
    reg_rd(4, 32'h0FFF_0000, "R7/R6 addr4");
    reg_rd(5, 32'h0000_0000, "R7/R6 addr5");
    // R9: disabled, nothing starts
    repeat (20) @(negedge clk_i);
    chk(n_acc == 0, "R9 no request while disabled", n_acc, 0);

    // default bitmap, one full round plus wrap-around (R1 R2 R3)
    run(53 + 7);
    // R9: restart from word 0 bit 11 after re-enable
    run(3);

    // R6 packing and reserved bits, R4 period tracking
    reg_wr(2, 32'hFFFF_FFFF);
    reg_rd(2, 32'h0FFF_0FFF, "R6 reserved bits");
    chk(period_o == 8'd77, "R4 period after write", int'(period_o), 77);
    reg_wr(6, 32'hFFFF_FFFF);
    reg_rd(6, 32'h0, "R6 addr6 reads zero");
    chk(period_o == 8'd77, "R6 addr6 write ignored", int'(period_o), 77);

    // sparse bitmap: word5=0x001, word11=0x801 (R2 R3)
    for (int a = 0; a < 6; a++) reg_wr(a, 32'h0);
    reg_wr(2, 32'h0001_0000);
    reg_wr(5, 32'h0801_0000);
    chk(period_o == 8'd3, "R4 sparse period", int'(period_o), 3);
    run(7);

    // all cleared (R8)
    reg_wr(2, 32'h0);
    reg_wr(5, 32'h0);
    chk(period_o == 8'd0, "R4 empty period", int'(period_o), 0);
    @(negedge clk_i);
    en_i = 1'b1;
    repeat (60) @(negedge clk_i);
    en_i = 1'b0;
    chk(n_unexp == 0, "R8 no request when empty", n_unexp, 0);

    // single bit at the very end: word11 bit0 (R1 R3)
    reg_wr(5, 32'h0001_0000);
    run(3);
    chk(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule